// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs interrupt entry for a small 8-bit processor core whose program counter and stack pointer are 16 bits wide. It holds a five-bit enable mask, a five-bit request flag register and a master enable. Once the master enable is set and some source is both flagged and enabled, it takes over the stack. It first waits two internal cycles. It then writes the return address as two single-byte stores, high byte first, each held until the memory acknowledges it. Finally it hands the core a new program counter and stack pointer.

The source that wins is not frozen when the interrupt is accepted. Arbitration happens in a dedicated cycle between the two stores, using whatever enable and flag values are present in that cycle. Software that rewrites the enable mask while the high byte is being stored can therefore steer the dispatch to another source. If it leaves nothing enabled and pending, the dispatch lands at address zero and no flag is acknowledged.

A request to turn the master enable on only takes effect after a fixed delay. A request to turn it off acts at once.

Top module: `irq_entry`

## Requirements
- R1: A dispatch begins (`busy` rises on the next clock edge) only when `ime` is 1, the block is idle, and the bitwise AND of the enable mask and the flag register is nonzero. Bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is keypad.
- R2: When a dispatch begins, `ime` drops to 0 in the same cycle that `busy` rises. `mem_we` stays low for that cycle and the next one, and is asserted in the third cycle of `busy`.
- R3: The first store writes `pc_in[15:8]` to address `sp_in - 1`. Address and data hold steady until `mem_ack` is seen high at a clock edge.
- R4: The second store writes `pc_in[7:0]` to address `sp_in - 2`. The one-cycle `pc_load` pulse that follows carries the vector on `pc_out` and `sp_in - 2` on `sp_out`, with `mem_we` low.
- R5: Priority runs from bit 0 (highest) to bit 4 (lowest). The vectors are 0x0040, 0x0048, 0x0050, 0x0058 and 0x0060 for bits 0 to 4.
- R6: Arbitration uses the enable and flag values in the cycle after the first store is acknowledged. An enable write that lands during the first store changes the selected vector.
- R7: If nothing is enabled and pending at arbitration, `pc_out` is 0x0000 and no flag bit is cleared.
- R8: Arbitration clears only the winning flag bit. Every other set flag bit stays set.
- R9: A request pulse on a source in the same cycle its flag is being acknowledged leaves that flag set.
- R10: After an `ime_set` pulse is sampled at a clock edge, `ime` reads 0 after each of the next three edges and 1 after the fourth. An `ime_clr` pulse forces `ime` to 0 at the next edge.
- R11: `ie_rdata` and `if_rdata` show the five register bits in bits 4:0, with bits 7:5 reading as 1.
- R12: After reset the enable mask and flags are zero (reads 0xE0), `ime` is 0, and `busy`, `mem_we` and `pc_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 5 | One-cycle request pulses, one per source |
| ie_we | input | 1 | Write strobe for the enable mask |
| if_we | input | 1 | Write strobe for the flag register |
| reg_wdata | input | 5 | Write data for either register |
| ie_rdata | output | 8 | Enable mask readback, upper bits set |
| if_rdata | output | 8 | Flag register readback, upper bits set |
| ime_set | input | 1 | Request to turn the master enable on (delayed) |
| ime_clr | input | 1 | Turn the master enable off immediately |
| ime | output | 1 | Master enable state |
| pc_in | input | 16 | Current program counter of the core |
| sp_in | input | 16 | Current stack pointer of the core |
| busy | output | 1 | Dispatch in progress |
| mem_we | output | 1 | Store request |
| mem_addr | output | 16 | Store address |
| mem_wdata | output | 8 | Store data byte |
| mem_ack | input | 1 | Store completed at this edge |
| pc_load | output | 1 | One-cycle pulse: load `pc_out` and `sp_out` |
| pc_out | output | 16 | New program counter (vector) |
| sp_out | output | 16 | New stack pointer |

## Verification
The assertions take the following for granted:
- `mem_ack` is only raised while `mem_we` is high.
- Nobody pulses `ime_set` while a dispatch is in flight, so the master enable cannot come back on partway through the sequence.
- `pc_in` and `sp_in` matter only in the cycle the dispatch is accepted.

The bench keeps within these limits in three ways. A single responder process raises the acknowledge only after it has seen a store request for a chosen number of cycles. Master-enable pulses are issued only from idle. Mid-sequence disturbances are limited to one enable write during the first store, or one request pulse during the arbitration cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int NSRC = 5;
    localparam int PC_W = 16;
    localparam int DW   = 8;
    localparam int RD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT1,
        ST_WAIT2,
        ST_PUSH_HI,
        ST_PICK,
        ST_PUSH_LO,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              hit;
        logic [NSRC-1:0]   onehot;
        logic [PC_W-1:0]   vector;
    } pick_t;

    function automatic logic [RD_W-1:0] pad_ones(input logic [NSRC-1:0] v);
        return {{(RD_W-NSRC){1'b1}}, v};
    endfunction

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int EI_DELAY = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic            ie_we,
    input  logic            if_we,
    input  logic [NSRC-1:0] reg_wdata,
    input  logic [NSRC-1:0] ack_mask,
    input  logic            ime_set,
    input  logic            ime_clr,
    input  logic            ime_drop,
    output logic [NSRC-1:0] ie_q,
    output logic [NSRC-1:0] if_q,
    output logic            ime
);
    localparam int CW = $clog2(EI_DELAY + 1);

    logic [CW-1:0]   ei_cnt;
    logic [NSRC-1:0] if_nxt;

    always_comb begin
        if_nxt = if_q;
        if (if_we) if_nxt = reg_wdata;
        if_nxt = if_nxt & ~ack_mask;
        if_nxt = if_nxt | src_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
            if_q <= '0;
        end else begin
            if (ie_we) ie_q <= reg_wdata;
            if_q <= if_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ime    <= 1'b0;
            ei_cnt <= '0;
        end else if (ime_drop || ime_clr) begin
            ime    <= 1'b0;
            ei_cnt <= '0;
        end else if (ime_set) begin
            ei_cnt <= CW'(EI_DELAY);
        end else if (ei_cnt == CW'(1)) begin
            ime    <= 1'b1;
            ei_cnt <= '0;
        end else if (ei_cnt != '0) begin
            ei_cnt <= ei_cnt - CW'(1);
        end
    end

    // R8: acknowledge never targets more than one source
    a_r8_single_clear: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_mask));

    // R9: a request colliding with its acknowledge survives
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|(ack_mask & src_req)) |=> (|(if_q & $past(ack_mask & src_req))));

    // R10: a fresh enable request never turns ime on in the very next cycle
    a_r10_ime_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(ime) |-> !$past(ime_set));

endmodule

// File: rtl/irqd_prio.sv
module irqd_prio
    import irqd_pkg::*;
#(
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8
) (
    input  logic [NSRC-1:0] pend,
    output pick_t           pick
);
    logic [PC_W-1:0] vec_tab [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_vec
        assign vec_tab[g] = PC_W'(VEC_BASE + VEC_STRIDE * g);
    end

    always_comb begin
        logic blocked;
        blocked = 1'b0;
        pick    = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && !blocked) begin
                pick.hit       = 1'b1;
                pick.onehot[i] = 1'b1;
                pick.vector    = vec_tab[i];
            end
            blocked = blocked | pend[i];
        end
    end

endmodule

// File: rtl/irqd_seq.sv
module irqd_seq
    import irqd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ime,
    input  pick_t           pick,
    input  logic [PC_W-1:0] pc_in,
    input  logic [PC_W-1:0] sp_in,
    input  logic            mem_ack,
    output logic            start,
    output logic            busy,
    output logic            mem_we,
    output logic [PC_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [NSRC-1:0] ack_mask,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_out,
    output logic [PC_W-1:0] sp_out
);
    seq_state_e      state;
    logic [PC_W-1:0] pc_sv;
    logic [PC_W-1:0] sp_sv;
    logic [PC_W-1:0] vec_q;

    assign start = (state == ST_IDLE) && ime && pick.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc_sv <= '0;
            sp_sv <= '0;
            vec_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_WAIT1;
                    pc_sv <= pc_in;
                    sp_sv <= sp_in;
                end
                ST_WAIT1:   state <= ST_WAIT2;
                ST_WAIT2:   state <= ST_PUSH_HI;
                ST_PUSH_HI: if (mem_ack) state <= ST_PICK;
                ST_PICK: begin
                    vec_q <= pick.vector;
                    state <= ST_PUSH_LO;
                end
                ST_PUSH_LO: if (mem_ack) state <= ST_DONE;
                ST_DONE:    state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_we    = (state == ST_PUSH_HI) || (state == ST_PUSH_LO);
        mem_addr  = (state == ST_PUSH_LO) ? sp_sv - PC_W'(2) : sp_sv - PC_W'(1);
        mem_wdata = (state == ST_PUSH_LO) ? pc_sv[DW-1:0] : pc_sv[PC_W-1 -: DW];
        ack_mask  = (state == ST_PICK) ? pick.onehot : '0;
        pc_load   = (state == ST_DONE);
        pc_out    = vec_q;
        sp_out    = sp_sv - PC_W'(2);
    end

    // R3: an unacknowledged store keeps its address and data
    a_r3_store_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    // R4: the load pulse never overlaps a store
    a_r4_load_quiet: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> !mem_we);

endmodule

// File: rtl/irq_entry.sv
module irq_entry
    import irqd_pkg::*;
#(
    parameter int EI_DELAY   = 4,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       src_req,
    input  logic             ie_we,
    input  logic             if_we,
    input  logic [4:0]       reg_wdata,
    output logic [7:0]       ie_rdata,
    output logic [7:0]       if_rdata,
    input  logic             ime_set,
    input  logic             ime_clr,
    output logic             ime,
    input  logic [15:0]      pc_in,
    input  logic [15:0]      sp_in,
    output logic             busy,
    output logic             mem_we,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic             mem_ack,
    output logic             pc_load,
    output logic [15:0]      pc_out,
    output logic [15:0]      sp_out
);
    logic [NSRC-1:0] ie_q;
    logic [NSRC-1:0] if_q;
    logic [NSRC-1:0] ack_mask;
    logic            start;
    pick_t           pick;

    irqd_regs #(.EI_DELAY(EI_DELAY)) u_regs (
        .clk(clk), .rst(rst), .src_req(src_req),
        .ie_we(ie_we), .if_we(if_we), .reg_wdata(reg_wdata),
        .ack_mask(ack_mask), .ime_set(ime_set), .ime_clr(ime_clr),
        .ime_drop(start), .ie_q(ie_q), .if_q(if_q), .ime(ime)
    );

    irqd_prio #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_prio (
        .pend(ie_q & if_q), .pick(pick)
    );

    irqd_seq u_seq (
        .clk(clk), .rst(rst), .ime(ime), .pick(pick),
        .pc_in(pc_in), .sp_in(sp_in), .mem_ack(mem_ack),
        .start(start), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ack_mask(ack_mask),
        .pc_load(pc_load), .pc_out(pc_out), .sp_out(sp_out)
    );

    assign ie_rdata = pad_ones(ie_q);
    assign if_rdata = pad_ones(if_q);

    // R1: a dispatch only starts from an enabled, pending state
    a_r1_start_cond: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(ime) && $past(|(ie_q & if_q))));

    // R2: the master enable is off as soon as a dispatch is running
    a_r2_ime_off: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !ime);

endmodule

// File: tb/test_irq_entry.sv
module test_irq_entry;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  src_req = '0;
    logic        ie_we = 1'b0, if_we = 1'b0;
    logic [4:0]  reg_wdata = '0;
    logic [7:0]  ie_rdata, if_rdata;
    logic        ime_set = 1'b0, ime_clr = 1'b0, ime;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic        busy, mem_we, mem_ack, pc_load;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata;

    int nchk = 0, nfail = 0;
    int ack_lat = 0, wcnt = 0, nwr = 0, loads = 0;
    logic [15:0] wa [0:3];
    logic [7:0]  wd [0:3];
    logic [15:0] got_pc, got_sp;

    always #2.5 clk = ~clk;

    irq_entry i_irq_entry (
        .clk(clk), .rst(rst), .src_req(src_req), .ie_we(ie_we), .if_we(if_we),
        .reg_wdata(reg_wdata), .ie_rdata(ie_rdata), .if_rdata(if_rdata),
        .ime_set(ime_set), .ime_clr(ime_clr), .ime(ime), .pc_in(pc_in),
        .sp_in(sp_in), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .pc_load(pc_load),
        .pc_out(pc_out), .sp_out(sp_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    // memory responder: acknowledges each store after ack_lat waiting cycles
    initial begin
        mem_ack = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_we && !mem_ack && wcnt >= ack_lat) begin
                mem_ack = 1'b1;
                if (nwr < 4) begin
                    wa[nwr] = mem_addr;
                    wd[nwr] = mem_wdata;
                end
                nwr++;
                wcnt = 0;
            end else begin
                mem_ack = 1'b0;
                if (mem_we) wcnt++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (pc_load) begin
                got_pc = pc_out;
                got_sp = sp_out;
                loads++;
            end
        end
    end

    task automatic write_regs(input logic [4:0] ie_v, input logic [4:0] if_v);
        reg_wdata = ie_v; ie_we = 1'b1; step; ie_we = 1'b0;
        reg_wdata = if_v; if_we = 1'b1; step; if_we = 1'b0;
    endtask

    task automatic arm;
        ime_set = 1'b1; step; ime_set = 1'b0;
        repeat (4) step;
    endtask

    // mode 0: plain; 1: enable write of val during first store; 2: request pulse val in arbitration cycle
    task automatic run_disp(input string req, input logic [4:0] ie_v, input logic [4:0] if_v,
                            input logic [15:0] pc, input logic [15:0] sp, input int lat,
                            input int mode, input logic [4:0] val,
                            input logic [15:0] exp_vec, input logic [7:0] exp_if);
        int  l0;
        bit  did;
        bit  act;
        write_regs(ie_v, if_v);
        pc_in = pc; sp_in = sp; ack_lat = lat; nwr = 0; wcnt = 0;
        arm;
        chk({req, " R10 ime on before dispatch"}, ime, 1);
        l0 = loads;
        step;
        chk({req, " R1 busy rises"}, busy, 1);
        chk({req, " R2 ime dropped"}, ime, 0);
        chk({req, " R2 no store in first busy cycle"}, mem_we, 0);
        step;
        chk({req, " R2 no store in second busy cycle"}, mem_we, 0);
        step;
        chk({req, " R2 store in third busy cycle"}, mem_we, 1);
        did = 0;
        for (int i = 0; i < 80 && loads == l0; i++) begin
            act = 0;
            if (mode == 1 && !did && mem_we && nwr == 0) begin
                reg_wdata = val; ie_we = 1'b1; did = 1; act = 1;
            end
            if (mode == 2 && !did && busy && !mem_we && nwr == 1) begin
                src_req = val; did = 1; act = 1;
            end
            step;
            if (act) begin ie_we = 1'b0; src_req = '0; end
        end
        chk({req, " load pulse seen"}, loads - l0, 1);
        chk({req, " R3 high store addr"}, wa[0], sp - 16'd1);
        chk({req, " R3 high store data"}, wd[0], pc[15:8]);
        chk({req, " R4 low store addr"}, wa[1], sp - 16'd2);
        chk({req, " R4 low store data"}, wd[1], pc[7:0]);
        chk({req, " R4 new sp"}, got_sp, sp - 16'd2);
        chk({req, " vector"}, got_pc, exp_vec);
        chk({req, " flags after"}, if_rdata, exp_if);
        step;
        chk({req, " R4 back to idle"}, busy, 0);
    endtask

    task automatic t_reset;
        chk("R12 ie reset", ie_rdata, 8'hE0);
        chk("R12 if reset", if_rdata, 8'hE0);
        chk("R12 ime reset", ime, 0);
        chk("R12 busy reset", busy, 0);
        chk("R12 mem_we reset", mem_we, 0);
        chk("R12 pc_load reset", pc_load, 0);
    endtask

    task automatic t_readback;
        write_regs(5'h1F, 5'h0A);
        chk("R11 ie all ones", ie_rdata, 8'hFF);
        chk("R11 if pattern", if_rdata, 8'hEA);
        write_regs(5'h00, 5'h00);
        chk("R11 ie cleared", ie_rdata, 8'hE0);
        chk("R11 if cleared", if_rdata, 8'hE0);
    endtask

    task automatic t_ime_timing;
        ime_set = 1'b1; step; ime_set = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10 ime still off", ime, 0);
            step;
        end
        chk("R10 ime off after third edge", ime, 0);
        step;
        chk("R10 ime on after fourth edge", ime, 1);
        ime_clr = 1'b1; step; ime_clr = 1'b0;
        chk("R10 ime_clr immediate", ime, 0);
    endtask

    task automatic t_masked;
        write_regs(5'h01, 5'h02);
        arm;
        repeat (10) step;
        chk("R1 masked flag no dispatch", busy, 0);
        chk("R1 masked flag ime stays", ime, 1);
        chk("R1 masked flag untouched", if_rdata, 8'hE2);
        ime_clr = 1'b1; step; ime_clr = 1'b0;
    endtask

    task automatic t_priority;
        for (int k = 0; k < 5; k++) begin
            logic [4:0] fl;
            fl = 5'h1F & ~5'((1 << k) - 1);
            run_disp("R5 R8 priority", 5'h1F, fl, 16'hA5C3 + 16'(k), 16'hD000, k % 3, 0, 5'h00,
                     16'h0040 + 16'(8 * k), {3'b111, fl & ~5'(1 << k)});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        t_reset;
        t_readback;
        t_ime_timing;
        t_masked;
        run_disp("R1 R3 R4 timer basic", 5'h04, 5'h04, 16'h1234, 16'hFFFE, 2, 0, 5'h00,
                 16'h0050, 8'hE0);
        t_priority;
        run_disp("R6 redirect", 5'h10, 5'h11, 16'h8001, 16'hC100, 3, 1, 5'h01,
                 16'h0040, 8'hF0);
        run_disp("R7 cancel", 5'h04, 5'h04, 16'h4321, 16'hC200, 3, 1, 5'h00,
                 16'h0000, 8'hE4);
        run_disp("R9 set beats clear", 5'h08, 5'h08, 16'h0F0F, 16'hC300, 1, 2, 5'h08,
                 16'h0058, 8'hE8);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule